// File: doc/BRIEF.md
# Banked true dual-port RAM

A single-clock dual-port memory in which both ports read and write, sharing one data width and one address width. When the address width is larger than the bank address width, the storage is built from identical banks of `2**BANK_AW` words. Each port uses its upper address bits to pick a bank. Its write enable goes to that bank alone. A read multiplexer at each port returns the word from the bank that port addressed one cycle earlier. When the address fits inside one bank, a single bank is built and no decode or selection logic is added.

The collision behaviour is the same as for one undivided RAM. A port that writes sees its own new data on its output in the next cycle. A port that reads a word which the other port writes in the same cycle gets the contents from before that write. If both ports write the same address in the same cycle, the result is undefined, and the user must not do it. The usual setting is a bank address width of 14, so 16384 words per bank. The parameter defaults are smaller so that the memory stays small at elaboration.

Top module: `banked_tdp_ram`

## Requirements
- R1: While rst_ni is low, both read outputs are zero, and they clear as soon as reset asserts, without waiting for a clock edge. Reset does not change the stored words, so a word written before a reset reads back unchanged after it.
- R2: A port that reads presents the word at its address on its read output one clock edge after the address is sampled.
- R3: A port that writes presents its own write data on its read output after that same edge, and the word is stored.
- R4: When one port reads an address that the other port writes in the same cycle, the reader gets the value stored before that write.
- R5: Address bits [ADDR_W-1:BANK_AW] select the bank and bits [BANK_AW-1:0] select the word within it. Two addresses that differ only in the bank bits are separate words.
- R6: Both ports complete their accesses in the same cycle when they address different words, including words in different banks.
- R7: The read multiplexer uses the bank index registered from the previous cycle. A port that moves to a different bank on every cycle gets back each addressed word in order.
- R8: With ADDR_W no larger than BANK_AW, the block is a single bank of 2**ADDR_W words in which every address bit selects the word, with the same latency and collision rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers and bank selects |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A registered read data |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B registered read data |

## Verification
The case that is hardest to reach is a mixed-port collision that occurs on the same cycle as a bank change at the reading port. In that case the old-data rule and the registered bank select both have to be right together. The fixed vectors set up such cycles on purpose, using addresses that differ only in the bank bit. After those, a random phase draws addresses from eight words, four low offsets in each of two banks, so that collisions and bank switches happen often. Every word is preloaded first, so each expected read value is defined.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  function automatic int unsigned bank_count(int unsigned aw, int unsigned baw);
    return (aw > baw) ? (32'd1 << (aw - baw)) : 32'd1;
  endfunction

  function automatic int unsigned sel_width(int unsigned aw, int unsigned baw);
    return (aw > baw) ? (aw - baw) : 32'd1;
  endfunction

  function automatic int unsigned local_aw(int unsigned aw, int unsigned baw);
    return (aw > baw) ? baw : aw;
  endfunction

endpackage

// File: rtl/rbk_bank.sv
module rbk_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // both write paths in one process; reads below see pre-edge contents
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) a_rdata_o <= '0;
    else         a_rdata_o <= a_we_i ? a_wdata_i : mem_q[a_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_rdata_o <= '0;
    else         b_rdata_o <= b_we_i ? b_wdata_i : mem_q[b_addr_i];
  end
endmodule

// File: rtl/rbk_port_decode.sv
module rbk_port_decode #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LAW    = 8,
  parameter int unsigned SEL_W  = 1,
  parameter int unsigned NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LAW-1:0]    loc_addr_o,
  output logic [NB-1:0]     bank_we_o,
  output logic [SEL_W-1:0]  sel_q_o
);
  logic [SEL_W-1:0] sel_d;

  assign loc_addr_o = addr_i[LAW-1:0];

  generate
    if (NB > 1) begin : g_split
      assign sel_d = addr_i[ADDR_W-1:LAW];
    end else begin : g_flat
      assign sel_d = '0;
    end
  endgenerate

  always_comb begin
    bank_we_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (we_i && (sel_d == SEL_W'(i))) bank_we_o[i] = 1'b1;
    end
  end

  // aligns output select with the one-cycle bank read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q_o <= '0;
    else         sel_q_o <= sel_d;
  end
endmodule

// File: rtl/rbk_rd_mux.sv
module rbk_rd_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NB     = 2,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [NB-1:0][DATA_W-1:0] bank_q_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [DATA_W-1:0]         rdata_o
);
  generate
    if (NB > 1) begin : g_sel
      assign rdata_o = bank_q_i[sel_i];
    end else begin : g_pass
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign rdata_o    = bank_q_i[0];
    end
  endgenerate
endmodule

// File: rtl/banked_tdp_ram.sv
module banked_tdp_ram
  import rbk_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned BANK_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned NB    = bank_count(ADDR_W, BANK_AW);
  localparam int unsigned SEL_W = sel_width(ADDR_W, BANK_AW);
  localparam int unsigned LAW   = local_aw(ADDR_W, BANK_AW);

  logic [LAW-1:0]            a_loc, b_loc;
  logic [NB-1:0]             a_bank_we, b_bank_we;
  logic [SEL_W-1:0]          a_sel_q, b_sel_q;
  logic [NB-1:0][DATA_W-1:0] a_bank_q, b_bank_q;

  rbk_port_decode #(.ADDR_W(ADDR_W), .LAW(LAW), .SEL_W(SEL_W), .NB(NB)) u_dec_a (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (a_we_i),
    .addr_i     (a_addr_i),
    .loc_addr_o (a_loc),
    .bank_we_o  (a_bank_we),
    .sel_q_o    (a_sel_q)
  );

  rbk_port_decode #(.ADDR_W(ADDR_W), .LAW(LAW), .SEL_W(SEL_W), .NB(NB)) u_dec_b (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (b_we_i),
    .addr_i     (b_addr_i),
    .loc_addr_o (b_loc),
    .bank_we_o  (b_bank_we),
    .sel_q_o    (b_sel_q)
  );

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      rbk_bank #(.DATA_W(DATA_W), .AW(LAW)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .a_we_i    (a_bank_we[g]),
        .a_addr_i  (a_loc),
        .a_wdata_i (a_wdata_i),
        .a_rdata_o (a_bank_q[g]),
        .b_we_i    (b_bank_we[g]),
        .b_addr_i  (b_loc),
        .b_wdata_i (b_wdata_i),
        .b_rdata_o (b_bank_q[g])
      );
    end
  endgenerate

  rbk_rd_mux #(.DATA_W(DATA_W), .NB(NB), .SEL_W(SEL_W)) u_mux_a (
    .bank_q_i (a_bank_q),
    .sel_i    (a_sel_q),
    .rdata_o  (a_rdata_o)
  );

  rbk_rd_mux #(.DATA_W(DATA_W), .NB(NB), .SEL_W(SEL_W)) u_mux_b (
    .bank_q_i (b_bank_q),
    .sel_i    (b_sel_q),
    .rdata_o  (b_rdata_o)
  );
endmodule

// File: rtl/rbk_chk.sv
module rbk_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_we_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic [DATA_W-1:0] a_wdata_i,
  input logic [DATA_W-1:0] a_rdata_o,
  input logic              b_we_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic [DATA_W-1:0] b_wdata_i,
  input logic [DATA_W-1:0] b_rdata_o
);
  // R1
  rst_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (a_rdata_o == '0 && b_rdata_o == '0));

  // R3
  a_new_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_i |=> (a_rdata_o == $past(a_wdata_i)));

  // R3
  b_new_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i |=> (b_rdata_o == $past(b_wdata_i)));

  // R4: repeated read with no prior-cycle write stays put, even if the other port writes now
  a_old_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !a_we_i && !$past(a_we_i) && !$past(b_we_i) &&
     a_addr_i == $past(a_addr_i)) |=> $stable(a_rdata_o));

  // R4
  b_old_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !b_we_i && !$past(a_we_i) && !$past(b_we_i) &&
     b_addr_i == $past(b_addr_i)) |=> $stable(b_rdata_o));

  // usage rule: no same-address dual write
  no_dual_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_we_i && b_we_i && a_addr_i == b_addr_i));
endmodule

bind banked_tdp_ram rbk_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rbk_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_we_i    (a_we_i),
  .a_addr_i  (a_addr_i),
  .a_wdata_i (a_wdata_i),
  .a_rdata_o (a_rdata_o),
  .b_we_i    (b_we_i),
  .b_addr_i  (b_addr_i),
  .b_wdata_i (b_wdata_i),
  .b_rdata_o (b_rdata_o)
);

// File: tb/tb_banked_tdp_ram.sv
module tb_banked_tdp_ram;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam int NV = 12;
  localparam int VW = 2 * (1 + AW + DW);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #5 clk = ~clk;

  logic          a_we, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wd, b_wd, a_rd, b_rd;

  logic          fa_we, fb_we;
  logic [5:0]    fa_addr, fb_addr;
  logic [15:0]   fa_wd, fb_wd, fa_rd, fb_rd;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [1 << AW];
  logic [AW-1:0] prev_a = '0;
  logic [AW-1:0] prev_b = '0;

  banked_tdp_ram #(.DATA_W(DW), .ADDR_W(AW), .BANK_AW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b_rd)
  );

  banked_tdp_ram #(.DATA_W(16), .ADDR_W(6), .BANK_AW(8)) dut_flat (
    .clk_i(clk), .rst_ni(rst_n),
    .a_we_i(fa_we), .a_addr_i(fa_addr), .a_wdata_i(fa_wd), .a_rdata_o(fa_rd),
    .b_we_i(fb_we), .b_addr_i(fb_addr), .b_wdata_i(fb_wd), .b_rdata_o(fb_rd)
  );

  // {we_a, addr_a, data_a, we_b, addr_b, data_b}; bank bit is addr[8]
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 9'h005, 32'hAAAA0001, 1'b1, 9'h105, 32'hBBBB0001},
    {1'b0, 9'h105, 32'h0,        1'b0, 9'h005, 32'h0},
    {1'b0, 9'h005, 32'h0,        1'b1, 9'h005, 32'hCCCC0002},
    {1'b0, 9'h005, 32'h0,        1'b0, 9'h105, 32'h0},
    {1'b1, 9'h1FF, 32'h11110004, 1'b0, 9'h1FF, 32'h0},
    {1'b0, 9'h0FF, 32'h0,        1'b0, 9'h1FF, 32'h0},
    {1'b0, 9'h1FF, 32'h0,        1'b0, 9'h0FF, 32'h0},
    {1'b0, 9'h0FF, 32'h0,        1'b0, 9'h1FF, 32'h0},
    {1'b1, 9'h010, 32'h22220008, 1'b1, 9'h110, 32'h33330008},
    {1'b1, 9'h010, 32'h44440009, 1'b0, 9'h010, 32'h0},
    {1'b0, 9'h010, 32'h0,        1'b0, 9'h110, 32'h0},
    {1'b0, 9'h110, 32'h0,        1'b1, 9'h110, 32'h5555000B}
  };

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic ws, logic wo, logic [AW-1:0] as,
                                   logic [AW-1:0] ao, logic [AW-1:0] pv);
    if (ws) return "R3";
    if (wo && as == ao) return "R4";
    if (as[AW-1] != pv[AW-1]) return "R7";
    if (as[AW-1] != ao[AW-1]) return "R6";
    return "R2";
  endfunction

  task automatic step(input logic wa, input logic [AW-1:0] aa, input logic [DW-1:0] da,
                      input logic wb, input logic [AW-1:0] ab, input logic [DW-1:0] db,
                      input string ta, input string tb);
    logic [DW-1:0] ea, eb;
    string ka, kb;
    @(negedge clk);
    a_we = wa; a_addr = aa; a_wd = da;
    b_we = wb; b_addr = ab; b_wd = db;
    ea = wa ? da : model[aa];
    eb = wb ? db : model[ab];
    ka = (ta != "") ? ta : tag_of(wa, wb, aa, ab, prev_a);
    kb = (tb != "") ? tb : tag_of(wb, wa, ab, aa, prev_b);
    if (wa) model[aa] = da;
    if (wb) model[ab] = db;
    prev_a = aa; prev_b = ab;
    @(posedge clk); #2;
    chk(ka, "port A", a_rd, ea);
    chk(kb, "port B", b_rd, eb);
  endtask

  task automatic fstep(input logic wa, input logic [5:0] aa, input logic [15:0] da,
                       input logic wb, input logic [5:0] ab, input logic [15:0] db,
                       input logic [15:0] ea, input logic [15:0] eb);
    @(negedge clk);
    fa_we = wa; fa_addr = aa; fa_wd = da;
    fb_we = wb; fb_addr = ab; fb_wd = db;
    @(posedge clk); #2;
    chk("R8", "flat port A", {16'h0, fa_rd}, {16'h0, ea});
    chk("R8", "flat port B", {16'h0, fb_rd}, {16'h0, eb});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    a_we = 0; b_we = 0; a_addr = '0; b_addr = '0; a_wd = '0; b_wd = '0;
    fa_we = 0; fb_we = 0; fa_addr = '0; fb_addr = '0; fa_wd = '0; fb_wd = '0;
    #1 rst_n = 1'b0;
    #10;
    chk("R1", "A in reset", a_rd, '0);
    chk("R1", "B in reset", b_rd, '0);
    @(negedge clk); rst_n = 1'b1;

    // preload every word: A fills bank 0, B fills bank 1
    for (int i = 0; i < 256; i++) begin
      step(1'b1, AW'(i), 32'hD0000000 | i, 1'b1, AW'(i + 256), 32'hD0000000 | (i + 256), "", "");
    end

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      step(e[VW-1], e[VW-2 -: AW], e[VW-2-AW -: DW],
           e[VW/2-1], e[VW/2-2 -: AW], e[VW/2-2-AW -: DW], "", "");
    end

    // R5: same low offset, different bank bit, distinct words
    step(1'b1, 9'h0A3, 32'h0BA00000, 1'b0, 9'h000, '0, "R5", "");
    step(1'b1, 9'h1A3, 32'h1BA00001, 1'b0, 9'h001, '0, "R5", "");
    step(1'b0, 9'h0A3, '0, 1'b0, 9'h1A3, '0, "R5", "R5");

    // R1: reset mid-run clears outputs only
    @(negedge clk); a_we = 0; b_we = 0; rst_n = 1'b0;
    #1;
    chk("R1", "A async clear", a_rd, '0);
    chk("R1", "B async clear", b_rd, '0);
    @(posedge clk); #2;
    chk("R1", "A held in reset", a_rd, '0);
    @(negedge clk); rst_n = 1'b1;
    prev_a = '0; prev_b = '0;
    step(1'b0, 9'h1A3, '0, 1'b0, 9'h0A3, '0, "R1", "R1");

    for (int i = 0; i < 400; i++) begin
      logic wa, wb;
      logic [AW-1:0] ra, rb;
      wa = 1'($urandom_range(0, 1));
      wb = 1'($urandom_range(0, 1));
      ra = {1'($urandom_range(0, 1)), 6'd0, 2'($urandom_range(0, 3))};
      rb = {1'($urandom_range(0, 1)), 6'd0, 2'($urandom_range(0, 3))};
      if (wa && wb && ra == rb) wb = 1'b0;
      step(wa, ra, $urandom, wb, rb, $urandom, "", "");
    end

    // R8: single-bank variant, top address bit is a word bit
    fstep(1'b1, 6'h01, 16'h1111, 1'b1, 6'h21, 16'h2222, 16'h1111, 16'h2222);
    fstep(1'b0, 6'h21, 16'h0,    1'b0, 6'h01, 16'h0,    16'h2222, 16'h1111);
    fstep(1'b0, 6'h01, 16'h0,    1'b1, 6'h01, 16'h3333, 16'h1111, 16'h3333);
    fstep(1'b0, 6'h01, 16'h0,    1'b0, 6'h21, 16'h0,    16'h3333, 16'h2222);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule